// File: doc/BRIEF.md
# Event-Selected Up/Down Counter

This block is a free-standing counter whose every action is chosen from a common pool of qualified events. The pool has 24 entries: edges of four external trigger lines, edges of two I/O pins where each pin's edge is split by the level of the other pin, and eight single-cycle internal link pulses. Seven 24-bit masks, one for each action, pick which entries fire that action. The actions are start, stop, clear, count up, count down, capture into register A and capture into register B. When any enabled entry in a mask occurs, its action fires.

When both step masks are zero, the counter runs on the clock. When either step mask is nonzero, the counter moves by one step only on a selected event. Because a pin edge can be qualified by the other pin's level, setting the up and down masks gives a quadrature decoder. Each capture channel stores the count in the cycle of its event and raises a strobe for one cycle.

Top module: `evt_timer`

## Requirements
- R1: After reset the count, both capture registers and both strobes are zero, and the counter is stopped.
- R2: Mask bits 2k and 2k+1 (k = 0..3) select the rising and the falling edge of trigger input k. An edge is a change against the value that input had in the previous cycle.
- R3: Mask bits 8, 9, 10 and 11 select: pin A rising with pin B low, pin A rising with pin B high, pin A falling with pin B low, pin A falling with pin B high. The level of pin B is the value it had in the previous cycle.
- R4: Mask bits 12 to 15 select the same four cases as R3, with pins A and B swapped.
- R5: Mask bits 16 to 23 select internal link inputs 0 to 7. A link input that is high in a cycle counts as one event in that cycle.
- R6: An action fires when any event enabled in its mask occurs.
- R7: While running with both step masks zero, the count rises by one on every clock. While stopped, the count holds unless cleared.
- R8: While running with a nonzero step mask, an up event adds one and a down event subtracts one, both modulo 2^CNT_W. Up and down events in the same cycle cancel.
- R9: A clear event sets the count to zero at the next edge, whether the counter is running or stopped, and it overrides any step.
- R10: A start event sets the running state and a stop event clears it, one edge later. A stop event overrides a start event in the same cycle.
- R11: A capture event loads that channel's register with the count held during the event cycle. The channel's strobe is high in the following cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_mask_i | input | 24 | Sources that start counting |
| stop_mask_i | input | 24 | Sources that stop counting |
| clear_mask_i | input | 24 | Sources that clear the count |
| up_mask_i | input | 24 | Sources that add one |
| down_mask_i | input | 24 | Sources that subtract one |
| cap_a_mask_i | input | 24 | Sources that load capture register A |
| cap_b_mask_i | input | 24 | Sources that load capture register B |
| trig_i | input | 4 | External trigger lines |
| pin_a_i | input | 1 | I/O pin A input level |
| pin_b_i | input | 1 | I/O pin B input level |
| link_i | input | 8 | Internal single-cycle event pulses |
| count_o | output | CNT_W | Current count |
| cap_a_o | output | CNT_W | Capture register A |
| cap_b_o | output | CNT_W | Capture register B |
| cap_a_stb_o | output | 1 | One-cycle strobe after a capture into A |
| cap_b_stb_o | output | 1 | One-cycle strobe after a capture into B |

## Verification
The bench builds the counter with CNT_W = 8. With this width, one down step from zero wraps to 255 and is easy to observe. Each of the 24 sources is tested in turn as the only up source and as the only down source, so every edge polarity and every pin-level qualification is tested in isolation. Directed sequences then cover free running, start and stop arbitration, clear while running, step cancellation, OR-ing of two sources and both capture channels.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [23:0]      start_mask_i,
  input  logic [23:0]      stop_mask_i,
  input  logic [23:0]      clear_mask_i,
  input  logic [23:0]      up_mask_i,
  input  logic [23:0]      down_mask_i,
  input  logic [23:0]      cap_a_mask_i,
  input  logic [23:0]      cap_b_mask_i,
  input  logic [3:0]       trig_i,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  input  logic [7:0]       link_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap_a_o,
  output logic [CNT_W-1:0] cap_b_o,
  output logic             cap_a_stb_o,
  output logic             cap_b_stb_o
);
  localparam int NTRIG = 4;
  localparam int NSRC  = 24;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [NTRIG-1:0] trig_q;
  logic             a_q, b_q, run_q;
  logic [NSRC-1:0]  ev;

  for (genvar k = 0; k < NTRIG; k++) begin : g_trig
    assign ev[2*k]   =  trig_i[k] & ~trig_q[k];
    assign ev[2*k+1] = ~trig_i[k] &  trig_q[k];
  end

  wire a_rise = pin_a_i & ~a_q;
  wire a_fall = ~pin_a_i & a_q;
  wire b_rise = pin_b_i & ~b_q;
  wire b_fall = ~pin_b_i & b_q;

  assign ev[11:8]  = {a_fall & b_q, a_fall & ~b_q, a_rise & b_q, a_rise & ~b_q};
  assign ev[15:12] = {b_fall & a_q, b_fall & ~a_q, b_rise & a_q, b_rise & ~a_q};
  assign ev[23:16] = link_i;

  wire hit_start = |(ev & start_mask_i);
  wire hit_stop  = |(ev & stop_mask_i);
  wire hit_clear = |(ev & clear_mask_i);
  wire hit_up    = |(ev & up_mask_i);
  wire hit_down  = |(ev & down_mask_i);
  wire hit_cap_a = |(ev & cap_a_mask_i);
  wire hit_cap_b = |(ev & cap_b_mask_i);
  wire free_run  = (up_mask_i == '0) && (down_mask_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      trig_q <= trig_i;
      a_q    <= pin_a_i;
      b_q    <= pin_b_i;
      if (hit_stop)       run_q <= 1'b0;
      else if (hit_start) run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
    end else if (hit_clear) begin
      count_o <= '0;
    end else if (run_q) begin
      if (free_run)                count_o <= count_o + ONE;
      else if (hit_up && !hit_down) count_o <= count_o + ONE;
      else if (hit_down && !hit_up) count_o <= count_o - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a_o     <= '0;
      cap_b_o     <= '0;
      cap_a_stb_o <= 1'b0;
      cap_b_stb_o <= 1'b0;
    end else begin
      cap_a_stb_o <= hit_cap_a;
      cap_b_stb_o <= hit_cap_b;
      if (hit_cap_a) cap_a_o <= count_o;
      if (hit_cap_b) cap_b_o <= count_o;
    end
  end

  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clear |=> (count_o == '0));

  a_r10_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stop |=> !run_q);

  a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !hit_clear) |=> $stable(count_o));

  a_r8_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run && hit_up && hit_down && !hit_clear) |=> $stable(count_o));

  a_r11_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cap_a |=> (cap_a_stb_o && cap_a_o == $past(count_o)));

  a_r11_capture_b: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cap_b |=> (cap_b_stb_o && cap_b_o == $past(count_o)));
endmodule

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n;
  logic [23:0] m_start, m_stop, m_clear, m_up, m_down, m_ca, m_cb;
  logic [3:0] trig;
  logic pa, pb;
  logic [7:0] link;
  logic [W-1:0] cnt, ca, cb;
  logic sa, sb;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_timer #(.CNT_W(W)) u_evt_timer (
    .clk(clk), .rst_n(rst_n),
    .start_mask_i(m_start), .stop_mask_i(m_stop), .clear_mask_i(m_clear),
    .up_mask_i(m_up), .down_mask_i(m_down),
    .cap_a_mask_i(m_ca), .cap_b_mask_i(m_cb),
    .trig_i(trig), .pin_a_i(pa), .pin_b_i(pb), .link_i(link),
    .count_o(cnt), .cap_a_o(ca), .cap_b_o(cb),
    .cap_a_stb_o(sa), .cap_b_stb_o(sb));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {m_start, m_stop, m_clear, m_up, m_down, m_ca, m_cb} = '0;
    trig = '0; pa = 1'b0; pb = 1'b0; link = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_link(int n);
    @(negedge clk);
    link[n] = 1'b1;
    @(negedge clk);
    link[n] = 1'b0;
  endtask

  task automatic prep(int i);
    int j;
    if (i < 8) trig[i/2] = i[0];
    else if (i < 16) begin
      j = i - 8;
      pb = j[0]; pa = j[1];
    end else if (i < 24 && i >= 16) begin
      j = 0;
    end
    if (i >= 12 && i < 16) begin
      j = i - 12;
      pa = j[0]; pb = j[1];
    end
  endtask

  task automatic fire(int i);
    if (i >= 16) pulse_link(i - 16);
    else begin
      @(negedge clk);
      if (i < 8) trig[i/2] = ~trig[i/2];
      else if (i < 12) pa = ~pa;
      else pb = ~pb;
    end
  endtask

  task automatic sweep(int i, bit down);
    string tag;
    tag = (i < 8) ? "R2" : (i < 12) ? "R3" : (i < 16) ? "R4" : "R5";
    do_reset();
    if (down) m_down = 24'(1) << i; else m_up = 24'(1) << i;
    m_start = (i < 16) ? 24'(1) << 23 : 24'(1);
    prep(i);
    repeat (2) @(negedge clk);
    if (i < 16) pulse_link(7);
    else begin
      @(negedge clk);
      trig[0] = 1'b1;
    end
    repeat (2) @(negedge clk);
    chk({tag, " no step before event"}, int'(cnt), 0);
    fire(i);
    repeat (3) @(negedge clk);
    chk({tag, " R8 one step"}, int'(cnt), down ? 255 : 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    do_reset();
    chk("R1 count", int'(cnt), 0);
    chk("R1 cap a", int'(ca), 0);
    chk("R1 cap b", int'(cb), 0);
    chk("R1 strobes", int'({sa, sb}), 0);
    repeat (3) @(negedge clk);
    chk("R1 R7 stopped after reset", int'(cnt), 0);

    for (int i = 0; i < 24; i++) begin
      sweep(i, 1'b0);
      sweep(i, 1'b1);
    end

    // R7 free running, R10 start/stop
    do_reset();
    m_start = (24'(1) << 23) | (24'(1) << 21);
    m_stop  = (24'(1) << 22) | (24'(1) << 21);
    m_clear = 24'(1) << 20;
    m_ca = 24'(1) << 19;
    m_cb = 24'(1) << 18;
    @(negedge clk);
    link[7] = 1'b1;
    @(negedge clk);
    link[7] = 1'b0;
    chk("R10 start takes one edge", int'(cnt), 0);
    repeat (10) @(negedge clk);
    chk("R7 free run", int'(cnt), 10);
    c = int'(cnt);
    link[6] = 1'b1;
    @(negedge clk);
    link[6] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 stop freezes", int'(cnt), c + 1);
    c = int'(cnt);
    pulse_link(5);
    repeat (4) @(negedge clk);
    chk("R10 stop wins over start", int'(cnt), c);
    pulse_link(4);
    @(negedge clk);
    chk("R9 clear while stopped", int'(cnt), 0);
    pulse_link(7);
    repeat (20) @(negedge clk);
    c = int'(cnt);
    link[4] = 1'b1;
    @(negedge clk);
    link[4] = 1'b0;
    chk("R9 clear beats counting", int'(cnt), 0);
    @(negedge clk);
    chk("R9 resumes after clear", int'(cnt), 1);

    // R11 capture
    repeat (5) @(negedge clk);
    c = int'(cnt);
    link[3] = 1'b1;
    @(negedge clk);
    link[3] = 1'b0;
    chk("R11 cap a value", int'(ca), c);
    chk("R11 strobe a high", int'(sa), 1);
    chk("R11 strobe b idle", int'(sb), 0);
    @(negedge clk);
    chk("R11 strobe a one cycle", int'(sa), 0);
    c = int'(cnt);
    link[2] = 1'b1;
    @(negedge clk);
    link[2] = 1'b0;
    chk("R11 cap b value", int'(cb), c);
    chk("R11 strobe b high", int'(sb), 1);
    @(negedge clk);
    chk("R11 strobe b one cycle", int'(sb), 0);

    // R8 cancel and R6 OR of sources
    do_reset();
    m_start = 24'(1) << 23;
    m_up = 24'(1) | (24'(1) << 16);
    m_down = 24'(1) << 2;
    pulse_link(7);
    @(negedge clk);
    trig[0] = 1'b1; trig[1] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 up and down cancel", int'(cnt), 0);
    trig = '0;
    @(negedge clk);
    trig[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 up alone", int'(cnt), 1);
    pulse_link(0);
    @(negedge clk);
    chk("R6 second up source", int'(cnt), 2);
    trig[0] = 1'b0;
    @(negedge clk);
    trig[1] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 down alone", int'(cnt), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule